// File: doc/BRIEF.md
# Multimode Serial Character Receiver

A serial receive channel that assembles bits from a serial data line into parallel characters. It runs in one of three modes. In asynchronous mode it finds start bits and samples each bit at its centre, using a receive clock that runs at sixteen times the bit rate. In internal-sync mode it searches the bit stream for one or two programmed sync characters. In external-sync mode a strobe on a shared pin marks where the first character starts. In both synchronous modes the receive clock runs at the bit rate.

A CPU reads the data register and a status register through a one-strobe read port. A ready output shows that an unread character is waiting. One bidirectional pin is brought out as an input plus an output with its enable, and its role follows the mode: a sync strobe input (external sync), a sync-found output (internal sync), or a break output (asynchronous). The character length, the parity, the sync characters and the mode are static configuration inputs. A hunt pulse restarts the sync search.

Top module: `mmsrx`

## Requirements
- R1: `rx_ready` goes high in the cycle after a character completes. It stays high through any status read. It falls on the clock edge after the falling edge of a read strobe with `rd_sel`=0. The data register is only written when a character completes.
- R2: Asynchronous mode (`mode`=00) uses 16 ticks per bit, where a tick is a rising edge of `rx_clk`. A low line is confirmed as a start bit on the 8th tick after it is first seen. Data bits follow LSB first. The character length is `len_sel`+5 bits. The data register holds the character right-aligned, with its unused upper bits at zero.
- R3: `par_sel` selects the parity: 0 none, 1 odd, 2 or 3 even. When parity is enabled, one parity bit follows the data. Status bit 1 shows that the parity check failed.
- R4: In asynchronous mode one stop bit follows the data and parity. If the sampled stop bit is 0, status bit 2 (framing error) is set.
- R5: In asynchronous mode `sb_oe`=1 and `sb_out` carries the break flag, which is also status bit 4. The flag is set when a frame has a framing error and every bit of it (start, data, parity, stop) was 0. It stays set until a tick samples `rxd`=1, or until reset.
- R6: In internal-sync mode (`mode`=01, `sb_oe`=1), the search compares the last `len_sel`+5 bits with the low bits of `sync_a` after every bit. On a match it sets the sync flag (`sb_out`, status bit 3) and ends the search. The next bit is the first data bit.
- R7: With `bisync`=1, the sync flag is set only when the `len_sel`+5 bits that directly follow a `sync_a` match also match `sync_b`. Otherwise the search goes on.
- R8: The sync flag falls on the clock edge after the falling edge of a read strobe with `rd_sel`=1.
- R9: In external-sync mode (`mode`=1x), `sb_oe`=0. During the search, if `sb_in` is high while `rx_clk` is high, the bit sampled at the next rising edge of `rx_clk` is the first data bit. Without that strobe no character is received.
- R10: Reset clears ready, sync and break. The status register reads 0 in asynchronous mode. In the synchronous modes the receiver starts in search. A `hunt` pulse in a synchronous mode returns it to search. Status bit 5 is high while a synchronous search is running, and bits 7:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| rx_clk | input | 1 | Receive clock; its rising edges are bit ticks |
| rxd | input | 1 | Serial data in |
| mode | input | 2 | 00 async, 01 internal sync, 1x external sync |
| bisync | input | 1 | Two sync characters in internal-sync mode |
| len_sel | input | 2 | Character length minus 5 |
| par_sel | input | 2 | 0 none, 1 odd, 2/3 even |
| sync_a | input | 8 | First sync character |
| sync_b | input | 8 | Second sync character |
| hunt | input | 1 | Restart the sync search (synchronous modes) |
| rd_strobe | input | 1 | CPU read strobe |
| rd_sel | input | 1 | 0 data register, 1 status register |
| rd_data | output | 8 | Read data |
| rx_ready | output | 1 | Unread character available |
| sb_in | input | 1 | Shared pin, input side |
| sb_out | output | 1 | Shared pin, output side |
| sb_oe | output | 1 | Shared pin, output enable |

## Verification
A wrong bit counter or a wrong tick phase shows up in the data register as a character shifted by one position, with the wrong parity or framing flags. It appears at the first completed frame, about one character time after the fault. A stuck search state shows at `sb_out` and status bit 5, and if the sync window is compared at the wrong point the sync flag never rises or rises one bit early. A break or sync flag that clears at the wrong moment can be seen at `sb_out` within one tick of the stimulus or one cycle after the read strobe.

// File: rtl/mmsrx.sv
module mmsrx #(
  parameter int TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_clk,
  input  logic       rxd,
  input  logic [1:0] mode,
  input  logic       bisync,
  input  logic [1:0] len_sel,
  input  logic [1:0] par_sel,
  input  logic [7:0] sync_a,
  input  logic [7:0] sync_b,
  input  logic       hunt,
  input  logic       rd_strobe,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic       rx_ready,
  input  logic       sb_in,
  output logic       sb_out,
  output logic       sb_oe
);
  localparam int LW = $clog2(TICKS);
  localparam logic [LW-1:0] T_LAST = LW'(TICKS - 1);
  localparam logic [LW-1:0] T_MID = LW'(TICKS / 2 - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_SYNC2, ST_DATA, ST_PAR, ST_STOP} st_t;

  st_t st;
  logic rclk_q, rd_q, rd_sel_q, arm, syncd, brk, allz, pbit, pe_q, fe_q;
  logic [LW-1:0] tcnt;
  logic [3:0] bcnt, hcnt;
  logic [7:0] sh, data_q;

  wire is_async = (mode == 2'b00);
  wire is_int = (mode == 2'b01);
  wire is_ext = mode[1];
  wire rise = rx_clk & ~rclk_q;
  wire rd_end = rd_q & ~rd_strobe;
  wire [3:0] nbits = 4'd5 + {2'b00, len_sel};
  wire [1:0] sft = 2'd3 - len_sel;
  wire [7:0] cmask = 8'hFF >> sft;
  wire [7:0] sh_n = {rxd, sh[7:1]};
  wire [7:0] win_n = sh_n >> sft;
  wire [7:0] win = sh >> sft;
  wire par_en = (par_sel != 2'd0);
  wire odd = (par_sel == 2'd1);
  wire bit_ev = rise & (~is_async | (tcnt == T_LAST));
  wire last = (bcnt == nbits - 4'd1);
  wire hit_a = (win_n == (sync_a & cmask));
  wire hit_b = (win_n == (sync_b & cmask));
  wire hunting = ~is_async & (st == ST_IDLE || st == ST_SYNC2);

  function automatic logic perr(input logic [7:0] d, input logic p, input logic en, input logic o);
    return en & (^d ^ p ^ o);
  endfunction

  assign rd_data = rd_sel ? {2'b00, hunting, brk, syncd, fe_q, pe_q, rx_ready} : data_q;
  assign sb_oe = ~is_ext;
  assign sb_out = is_int ? syncd : (is_async ? brk : 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      rclk_q <= 1'b0;
      rd_q <= 1'b0;
      rd_sel_q <= 1'b0;
      arm <= 1'b0;
      syncd <= 1'b0;
      brk <= 1'b0;
      allz <= 1'b0;
      pbit <= 1'b0;
      pe_q <= 1'b0;
      fe_q <= 1'b0;
      rx_ready <= 1'b0;
      tcnt <= '0;
      bcnt <= '0;
      hcnt <= '0;
      sh <= '0;
      data_q <= '0;
    end else begin
      rclk_q <= rx_clk;
      rd_q <= rd_strobe;
      if (rd_strobe) rd_sel_q <= rd_sel;
      if (rd_end && !rd_sel_q) rx_ready <= 1'b0;
      if (rd_end && rd_sel_q) syncd <= 1'b0;
      if (is_async && rise && rxd) brk <= 1'b0;
      if (is_ext && st == ST_IDLE && rclk_q && rx_clk && sb_in) arm <= 1'b1;

      if (hunt && !is_async) begin
        st <= ST_IDLE;
        hcnt <= '0;
        arm <= 1'b0;
      end else if (rise) begin
        case (st)
          ST_IDLE: begin
            if (is_async) begin
              if (!rxd) begin
                st <= ST_START;
                tcnt <= '0;
              end
            end else if (is_int) begin
              sh <= sh_n;
              if (hcnt < nbits) hcnt <= hcnt + 4'd1;
              if (hcnt >= nbits - 4'd1 && hit_a) begin
                bcnt <= '0;
                if (bisync) st <= ST_SYNC2;
                else begin
                  syncd <= 1'b1;
                  st <= ST_DATA;
                end
              end
            end else if (arm) begin
              arm <= 1'b0;
              sh <= sh_n;
              bcnt <= 4'd1;
              st <= ST_DATA;
            end
          end
          ST_START: begin
            if (tcnt == T_MID) begin
              tcnt <= '0;
              if (!rxd) begin
                st <= ST_DATA;
                bcnt <= '0;
                allz <= 1'b1;
              end else st <= ST_IDLE;
            end else tcnt <= tcnt + 1'b1;
          end
          ST_SYNC2: begin
            sh <= sh_n;
            bcnt <= bcnt + 4'd1;
            if (last) begin
              bcnt <= '0;
              if (hit_b) begin
                syncd <= 1'b1;
                st <= ST_DATA;
              end else if (!hit_a) st <= ST_IDLE;
            end
          end
          ST_DATA: begin
            tcnt <= tcnt + 1'b1;
            if (bit_ev) begin
              sh <= sh_n;
              allz <= allz & ~rxd;
              bcnt <= bcnt + 4'd1;
              if (last) begin
                bcnt <= '0;
                if (par_en) st <= ST_PAR;
                else if (is_async) st <= ST_STOP;
                else begin
                  data_q <= win_n;
                  pe_q <= 1'b0;
                  fe_q <= 1'b0;
                  rx_ready <= 1'b1;
                end
              end
            end
          end
          ST_PAR: begin
            tcnt <= tcnt + 1'b1;
            if (bit_ev) begin
              pbit <= rxd;
              allz <= allz & ~rxd;
              if (is_async) st <= ST_STOP;
              else begin
                data_q <= win;
                pe_q <= perr(win, rxd, par_en, odd);
                fe_q <= 1'b0;
                rx_ready <= 1'b1;
                st <= ST_DATA;
              end
            end
          end
          ST_STOP: begin
            tcnt <= tcnt + 1'b1;
            if (bit_ev) begin
              data_q <= win;
              pe_q <= perr(win, pbit, par_en, odd);
              fe_q <= ~rxd;
              rx_ready <= 1'b1;
              if (!rxd && allz) brk <= 1'b1;
              st <= ST_IDLE;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

module mmsrx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_strobe,
  input logic       rxd,
  input logic       rd_q,
  input logic       rd_sel_q,
  input logic       rdy,
  input logic       syncd,
  input logic       brk,
  input logic       fe_q,
  input logic       hunting,
  input logic [7:0] data_q
);
  // R1
  rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(rd_q && !rd_strobe && !rd_sel_q));
  // R1
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> rdy);
  // R8
  sync_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(syncd) |-> $past(rd_q && !rd_strobe && rd_sel_q));
  // R6
  sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(syncd) |-> $past(hunting));
  // R5
  brk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk) |-> fe_q);
  // R5
  brk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk) |-> $past(rxd));
endmodule

bind mmsrx mmsrx_chk chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rxd(rxd),
  .rd_q(rd_q), .rd_sel_q(rd_sel_q), .rdy(rx_ready), .syncd(syncd),
  .brk(brk), .fe_q(fe_q), .hunting(hunting), .data_q(data_q)
);

// File: tb/mmsrx_test.sv
module mmsrx_test;
  logic clk = 0, rst_n = 0, rx_clk = 0, rxd = 1, bisync = 0, hunt = 0;
  logic rd_strobe = 0, rd_sel = 0, sb_in = 0;
  logic [1:0] mode = 0, len_sel = 3, par_sel = 0;
  logic [7:0] sync_a = 0, sync_b = 0;
  logic [7:0] rd_data;
  logic rx_ready, sb_out, sb_oe;
  int nchk = 0, nerr = 0;
  logic [7:0] v;

  mmsrx uut (.clk(clk), .rst_n(rst_n), .rx_clk(rx_clk), .rxd(rxd), .mode(mode),
    .bisync(bisync), .len_sel(len_sel), .par_sel(par_sel), .sync_a(sync_a),
    .sync_b(sync_b), .hunt(hunt), .rd_strobe(rd_strobe), .rd_sel(rd_sel),
    .rd_data(rd_data), .rx_ready(rx_ready), .sb_in(sb_in), .sb_out(sb_out), .sb_oe(sb_oe));

  always #4 clk = ~clk;

  // len, par, data, bad parity, stop, expected data, expected pe, expected fe
  localparam logic [39:0] VEC [7] = '{
    40'h30A501A500, 40'h313C013C00, 40'h3281118110, 40'h00FF011F00,
    40'h122D002D01, 40'h2155115510, 40'h2300010000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    rx_clk = 1; @(negedge clk); rx_clk = 0; @(negedge clk);
  endtask

  task automatic abit(input logic b);
    rxd = b; repeat (16) tick();
  endtask

  task automatic sbyte(input logic [7:0] d, input int n);
    for (int i = 0; i < n; i++) begin rxd = d[i]; tick(); end
  endtask

  task automatic rd(input logic sel, output logic [7:0] val);
    rd_sel = sel; rd_strobe = 1; @(negedge clk); val = rd_data;
    rd_strobe = 0; @(negedge clk); @(negedge clk);
  endtask

  task automatic afr(input int len, input logic [1:0] par, input logic [7:0] d,
                     input logic bad, input logic stop);
    logic [7:0] m;
    logic p;
    m = d & (8'hFF >> (3 - len));
    p = ((par == 2'd1) ? ~^m : ^m) ^ bad;
    abit(0);
    for (int i = 0; i < 5 + len; i++) abit(d[i]);
    if (par != 2'd0) abit(p);
    abit(stop);
    rxd = 1;
  endtask

  task automatic pulse_hunt();
    hunt = 1; @(negedge clk); hunt = 0; @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 ready after reset", rx_ready, 0);
    rst_n = 1; @(negedge clk);
    rd(1, v); chk("R10 status after reset", v, 8'h00);
    chk("R5 pin driven in async", sb_oe, 1);
    chk("R5 no break after reset", sb_out, 0);
    repeat (4) tick();

    foreach (VEC[k]) begin
      len_sel = VEC[k][37:36]; par_sel = VEC[k][33:32];
      afr(VEC[k][37:36], VEC[k][33:32], VEC[k][31:24], VEC[k][20], VEC[k][16]);
      repeat (20) tick();
      chk("R1 ready after frame", rx_ready, 1);
      rd(1, v);
      chk("R3 parity flag", v[1], VEC[k][4]);
      chk("R4 framing flag", v[2], VEC[k][0]);
      chk("R5 no break on nonzero frame", v[4], 0);
      chk("R1 status read keeps ready", rx_ready, 1);
      rd(0, v);
      chk("R2 data value", v, VEC[k][15:8]);
      chk("R1 ready cleared by data read", rx_ready, 0);
    end

    len_sel = 3; par_sel = 0;
    afr(3, 0, 8'h6E, 0, 1);
    repeat (4) tick();
    rd_sel = 0; rd_strobe = 1; repeat (3) @(negedge clk);
    chk("R1 ready held during strobe", rx_ready, 1);
    rd_strobe = 0; @(negedge clk); @(negedge clk);
    chk("R1 ready low after strobe", rx_ready, 0);

    par_sel = 2;
    afr(3, 2, 8'h00, 0, 0);
    chk("R5 break raised", sb_out, 1);
    rd(1, v); chk("R5 break and framing in status", v[4:2], 3'b101);
    rd(0, v);
    tick();
    chk("R5 break held until a one", sb_out, 0);
    repeat (20) tick();
    par_sel = 0;

    mode = 1; bisync = 0; len_sel = 3; sync_a = 8'h16;
    pulse_hunt();
    rd(1, v); chk("R10 hunting after hunt", v[5], 1);
    chk("R6 pin driven in internal sync", sb_oe, 1);
    sbyte(8'hFF, 8);
    chk("R6 no sync on other pattern", sb_out, 0);
    sbyte(8'h16, 8);
    chk("R6 sync found", sb_out, 1);
    sbyte(8'hC3, 8);
    chk("R6 first char after sync", rx_ready, 1);
    rd(0, v); chk("R6 char data", v, 8'hC3);
    rd(1, v); chk("R6 status sync set, hunt over", v[5:3], 3'b001);
    chk("R8 sync cleared by status read", sb_out, 0);

    len_sel = 0; sync_a = 8'hEB;
    pulse_hunt();
    sbyte(8'h1F, 5);
    sbyte(8'h0B, 5);
    chk("R6 short sync uses low bits", sb_out, 1);
    sbyte(8'h13, 5);
    rd(0, v); chk("R2 five bit char in sync mode", v, 8'h13);
    rd(1, v);

    len_sel = 3; sync_a = 8'h16; sync_b = 8'h2A; bisync = 1;
    pulse_hunt();
    sbyte(8'h16, 8);
    sbyte(8'h00, 8);
    chk("R7 first sync alone not enough", sb_out, 0);
    sbyte(8'h16, 8);
    chk("R7 still waiting for second", sb_out, 0);
    sbyte(8'h2A, 8);
    chk("R7 both syncs matched", sb_out, 1);
    sbyte(8'h5A, 8);
    rd(0, v); chk("R7 data after bisync", v, 8'h5A);
    rd(1, v);
    bisync = 0;

    mode = 2;
    @(negedge clk);
    chk("R9 pin is input in external sync", sb_oe, 0);
    pulse_hunt();
    sbyte(8'h9E, 8);
    chk("R9 nothing without strobe", rx_ready, 0);
    sb_in = 1; rx_clk = 1; @(negedge clk); @(negedge clk);
    rx_clk = 0; sb_in = 0; @(negedge clk);
    sbyte(8'h9E, 8);
    chk("R9 char after strobe", rx_ready, 1);
    rd(0, v); chk("R9 char data", v, 8'h9E);
    rd(1, v); chk("R10 framing, not hunting", v[5], 0);
    pulse_hunt();
    rd(1, v); chk("R10 hunt pulse restarts search", v[5], 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule